// File: doc/BRIEF.md
# Parallel Port Configuration and Diagnostic Register Block

This block holds the two 16-bit configuration registers of a parallel port: a timing register and an operation register. The timing register supplies a setup count and a strobe/acknowledge width count to the port's timers. The operation register selects the handshake style, the direction of each control line, soft reset, memory-clear control and diagnostic mode. Software reads and writes both registers over a simple single-cycle register bus. Reads of reserved positions always return their fixed values.

The block also carries the diagnostic path. When diagnostic mode is on, the three low bits of the output data register are looped onto the input data view. The strobe, acknowledge and busy status seen by software and by the interrupt sources comes from the internal latches rather than from the pins. The strobe and acknowledge outputs are forced inactive, busy is forced active, and the direction output holds the value it had when the mode was entered.

The timers, the handshake state machines and the memory-clear datapath sit outside this block. The block only feeds them their configuration and passes their counter values and idle flag back for reading.

Top module: `pp_port_cfg`

## Requirements
- R1: After reset the timing register reads 0x0000, the loaded width is 3, and with `idle_i`=1 the operation register reads 0x200A. That value is the strobe direction select (bit 13), the constant one (bit 1) and idle (bit 3).
- R2: A write to address 0 (timing) or 1 (operation) is visible on reads from the next clock. Timing bits 6:0 are the setup count, bits 14:8 the width count, and bit 15 the test bit. Bit 7 reads 0.
- R3: `width_ld_o` equals the stored width count when that count is 3 or more, and 3 when it is 0, 1 or 2.
- R4: In the operation register, bits 0, 2, 4, 5 and 6 read 0 and bit 1 reads 1, whatever was written. Bit 3 reads the `idle_i` input.
- R5: Operation bits 8 to 15 drive the outputs ack handshake, busy handshake, diagnostic, ack direction, busy direction, strobe direction, memory-clear source and memory-clear enable, in that order.
- R6: Operation bit 7 drives `srst_o`. It stays set until software writes it to 0, and setting it changes no register content.
- R7: While the test bit is 1, a read of the timing register returns the counter inputs: setup counter in bits 6:0, width counter in bits 14:8, bit 15 reads 1 and bit 7 reads 0.
- R8: Address 2 reads the input data in bits 7:0 and the status in bits 10:8 (strobe, ack, busy). In diagnostic mode, data bits 2:0 come from `out_data_i[2:0]`. Data bits 7:3 always come from `pin_data_i`.
- R9: In diagnostic mode, the status field and `irq_src_o` come from `lat_stat_i`. Otherwise they come from `pin_stat_i`.
- R10: In diagnostic mode `stb_o` and `ack_o` are 0, `busy_o` is 1, and `dir_o` holds the `core_dir_i` value sampled at the clock that entered the mode. Otherwise these outputs follow the core inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 timing, 1 operation, 2 input view |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| idle_i | input | 1 | Transfer state machines idle |
| cnt_setup_i | input | 7 | Live setup counter value |
| cnt_width_i | input | 7 | Live width counter value |
| out_data_i | input | 8 | Output data register value |
| pin_data_i | input | 8 | Data pins |
| pin_stat_i | input | 3 | Strobe, ack, busy pin levels |
| lat_stat_i | input | 3 | Strobe, ack, busy internal latches |
| core_stb_i | input | 1 | Strobe from handshake logic |
| core_ack_i | input | 1 | Ack from handshake logic |
| core_busy_i | input | 1 | Busy from handshake logic |
| core_dir_i | input | 1 | Direction from handshake logic |
| setup_o | output | 7 | Setup count |
| width_ld_o | output | 7 | Clamped width count |
| test_o | output | 1 | Counter readback enabled |
| ack_hs_o | output | 1 | Ack handshake mode |
| busy_hs_o | output | 1 | Busy handshake mode |
| diag_o | output | 1 | Diagnostic mode |
| ack_dir_o | output | 1 | Ack direction select |
| busy_dir_o | output | 1 | Busy direction select |
| stb_dir_o | output | 1 | Strobe direction select |
| mclr_src_o | output | 1 | Memory-clear data source |
| mclr_en_o | output | 1 | Memory-clear enable |
| srst_o | output | 1 | Soft reset of state machines and timers |
| irq_src_o | output | 3 | Strobe, ack, busy interrupt sources |
| stb_o | output | 1 | Strobe pin drive |
| ack_o | output | 1 | Ack pin drive |
| busy_o | output | 1 | Busy pin drive |
| dir_o | output | 1 | Direction pin drive |

## Verification
The bench walks the width count through 0, 1, 2, 3 and 4. An off-by-one clamp would show up as a 2 or a 4 on the loaded width. It writes all ones and all zeros to the operation register. This exposes reserved bits that store data, a missing constant one, or an idle bit that is stored rather than live. Soft reset is held across several cycles while the timing register is read back, which catches a soft reset that clears registers or clears itself. In diagnostic mode the bench changes the core direction after entry and checks the pin gating, the three-bit loopback boundary and the status source. A design that tracks the direction or loops too many data bits fails those checks.

// File: rtl/pp_cfg_pkg.sv
package pp_cfg_pkg;
  localparam int REG_W = 16;
  localparam int CNT_W = 7;

  localparam int TM_SET_LSB = 0;
  localparam int TM_WID_LSB = 8;
  localparam int TM_TEST    = 15;

  localparam int OP_ONE  = 1;
  localparam int OP_IDLE = 3;
  localparam int OP_CTL_LSB = 7;

  typedef struct packed {
    logic men;
    logic msrc;
    logic stb_dir;
    logic bsy_dir;
    logic ack_dir;
    logic diag;
    logic bsy_hs;
    logic ack_hs;
    logic srst;
  } op_ctl_t;

  localparam int CTL_W = $bits(op_ctl_t);

  typedef enum logic [1:0] {
    A_TIMING = 2'd0,
    A_OPER   = 2'd1,
    A_INPUT  = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pp_timing_reg.sv
module pp_timing_reg
  import pp_cfg_pkg::*;
#(
  parameter int W_CNT     = CNT_W,
  parameter int MIN_WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [W_CNT-1:0] cnt_setup_i,
  input  logic [W_CNT-1:0] cnt_width_i,
  output logic [REG_W-1:0] rd_data,
  output logic [W_CNT-1:0] setup_o,
  output logic [W_CNT-1:0] width_ld_o,
  output logic             test_o
);
  localparam logic [W_CNT-1:0] MIN_W = W_CNT'(MIN_WIDTH);

  logic [W_CNT-1:0] setup_q, setup_d;
  logic [W_CNT-1:0] width_q, width_d;
  logic             test_q, test_d;

  always_comb begin
    setup_d = setup_q;
    width_d = width_q;
    test_d  = test_q;
    if (wr_en) begin
      setup_d = wr_data[TM_SET_LSB +: W_CNT];
      width_d = wr_data[TM_WID_LSB +: W_CNT];
      test_d  = wr_data[TM_TEST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      width_q <= '0;
      test_q  <= 1'b0;
    end else begin
      setup_q <= setup_d;
      width_q <= width_d;
      test_q  <= test_d;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[TM_TEST] = test_q;
    if (test_q) begin
      rd_data[TM_SET_LSB +: W_CNT] = cnt_setup_i;
      rd_data[TM_WID_LSB +: W_CNT] = cnt_width_i;
    end else begin
      rd_data[TM_SET_LSB +: W_CNT] = setup_q;
      rd_data[TM_WID_LSB +: W_CNT] = width_q;
    end
  end

  assign setup_o    = setup_q;
  assign width_ld_o = (width_q < MIN_W) ? MIN_W : width_q;
  assign test_o     = test_q;

  assert_width_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    width_ld_o >= MIN_W);
  assert_width_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q >= MIN_W) |-> (width_ld_o == width_q));
  assert_timing_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (setup_q == $past(wr_data[TM_SET_LSB +: W_CNT])));
endmodule

// File: rtl/pp_op_reg.sv
module pp_op_reg
  import pp_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             idle_i,
  output logic [REG_W-1:0] rd_data,
  output op_ctl_t          ctl_o
);
  localparam op_ctl_t CTL_RST = '{stb_dir: 1'b1, default: 1'b0};

  op_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = op_ctl_t'(wr_data[OP_CTL_LSB +: CTL_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_d;
  end

  always_comb begin
    rd_data = '0;
    rd_data[OP_CTL_LSB +: CTL_W] = ctl_q;
    rd_data[OP_IDLE] = idle_i;
    rd_data[OP_ONE]  = 1'b1;
  end

  assign ctl_o = ctl_q;

  assert_srst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.srst && !wr_en) |=> ctl_q.srst);
  assert_op_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[OP_ONE] == 1'b1) && (rd_data[2:0] == 3'b010) && (rd_data[6:4] == 3'b000));
endmodule

// File: rtl/pp_diag_path.sv
module pp_diag_path #(
  parameter int DATA_W    = 8,
  parameter int LOOP_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              diag_i,
  input  logic [DATA_W-1:0] out_data_i,
  input  logic [DATA_W-1:0] pin_data_i,
  input  logic [2:0]        pin_stat_i,
  input  logic [2:0]        lat_stat_i,
  input  logic              core_stb_i,
  input  logic              core_ack_i,
  input  logic              core_busy_i,
  input  logic              core_dir_i,
  output logic [DATA_W-1:0] in_data_o,
  output logic [2:0]        stat_o,
  output logic [2:0]        irq_src_o,
  output logic              stb_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              dir_o
);
  logic dir_hold_q, dir_hold_d;

  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    if (i < LOOP_BITS) begin : g_loop
      assign in_data_o[i] = diag_i ? out_data_i[i] : pin_data_i[i];
    end else begin : g_pin
      assign in_data_o[i] = pin_data_i[i];
    end
  end

  assign stat_o    = diag_i ? lat_stat_i : pin_stat_i;
  assign irq_src_o = stat_o;

  always_comb begin
    dir_hold_d = dir_hold_q;
    if (!diag_i) dir_hold_d = core_dir_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_hold_q <= 1'b0;
    else        dir_hold_q <= dir_hold_d;
  end

  assign stb_o  = diag_i ? 1'b0 : core_stb_i;
  assign ack_o  = diag_i ? 1'b0 : core_ack_i;
  assign busy_o = diag_i ? 1'b1 : core_busy_i;
  assign dir_o  = diag_i ? dir_hold_q : core_dir_i;

  assert_diag_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    diag_i |-> (busy_o && !stb_o && !ack_o));
  assert_dir_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_i && $past(diag_i)) |-> $stable(dir_o));
  assert_upper_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_data_o[DATA_W-1:LOOP_BITS] == pin_data_i[DATA_W-1:LOOP_BITS]);
endmodule

// File: rtl/pp_port_cfg.sv
module pp_port_cfg
  import pp_cfg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOOP_BITS = 3,
  parameter int MIN_WIDTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              idle_i,
  input  logic [CNT_W-1:0]  cnt_setup_i,
  input  logic [CNT_W-1:0]  cnt_width_i,
  input  logic [DATA_W-1:0] out_data_i,
  input  logic [DATA_W-1:0] pin_data_i,
  input  logic [2:0]        pin_stat_i,
  input  logic [2:0]        lat_stat_i,
  input  logic              core_stb_i,
  input  logic              core_ack_i,
  input  logic              core_busy_i,
  input  logic              core_dir_i,
  output logic [CNT_W-1:0]  setup_o,
  output logic [CNT_W-1:0]  width_ld_o,
  output logic              test_o,
  output logic              ack_hs_o,
  output logic              busy_hs_o,
  output logic              diag_o,
  output logic              ack_dir_o,
  output logic              busy_dir_o,
  output logic              stb_dir_o,
  output logic              mclr_src_o,
  output logic              mclr_en_o,
  output logic              srst_o,
  output logic [2:0]        irq_src_o,
  output logic              stb_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              dir_o
);
  localparam int PAD_W = REG_W - 3 - DATA_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             wr_tm, wr_op;
  logic [REG_W-1:0] tm_rd, op_rd;
  logic [DATA_W-1:0] in_data;
  logic [2:0]       stat;
  op_ctl_t          ctl;
  reg_addr_e        addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign addr  = reg_addr_e'(bus_addr);
  assign wr_tm = bus_wr && (addr == A_TIMING);
  assign wr_op = bus_wr && (addr == A_OPER);

  pp_timing_reg #(.W_CNT(CNT_W), .MIN_WIDTH(MIN_WIDTH)) u_tm (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_tm), .wr_data(bus_wdata),
    .cnt_setup_i(cnt_setup_i), .cnt_width_i(cnt_width_i), .rd_data(tm_rd),
    .setup_o(setup_o), .width_ld_o(width_ld_o), .test_o(test_o)
  );

  pp_op_reg u_op (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_op), .wr_data(bus_wdata),
    .idle_i(idle_i), .rd_data(op_rd), .ctl_o(ctl)
  );

  pp_diag_path #(.DATA_W(DATA_W), .LOOP_BITS(LOOP_BITS)) u_diag (
    .clk(clk), .rst_n(rst_int_n), .diag_i(ctl.diag),
    .out_data_i(out_data_i), .pin_data_i(pin_data_i),
    .pin_stat_i(pin_stat_i), .lat_stat_i(lat_stat_i),
    .core_stb_i(core_stb_i), .core_ack_i(core_ack_i),
    .core_busy_i(core_busy_i), .core_dir_i(core_dir_i),
    .in_data_o(in_data), .stat_o(stat), .irq_src_o(irq_src_o),
    .stb_o(stb_o), .ack_o(ack_o), .busy_o(busy_o), .dir_o(dir_o)
  );

  always_comb begin
    unique case (addr)
      A_TIMING: bus_rdata = tm_rd;
      A_OPER:   bus_rdata = op_rd;
      A_INPUT:  bus_rdata = {{PAD_W{1'b0}}, stat, in_data};
      default:  bus_rdata = '0;
    endcase
  end

  assign ack_hs_o   = ctl.ack_hs;
  assign busy_hs_o  = ctl.bsy_hs;
  assign diag_o     = ctl.diag;
  assign ack_dir_o  = ctl.ack_dir;
  assign busy_dir_o = ctl.bsy_dir;
  assign stb_dir_o  = ctl.stb_dir;
  assign mclr_src_o = ctl.msrc;
  assign mclr_en_o  = ctl.men;
  assign srst_o     = ctl.srst;

  assert_op_write_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_op |=> (mclr_en_o == $past(bus_wdata[15]) && ack_hs_o == $past(bus_wdata[8])));
  assert_status_src_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    diag_o |-> (irq_src_o == lat_stat_i));
endmodule

// File: tb/tb_pp_port_cfg.sv
module tb_pp_port_cfg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        idle_i;
  logic [6:0]  cnt_setup_i, cnt_width_i, setup_o, width_ld_o;
  logic [7:0]  out_data_i, pin_data_i;
  logic [2:0]  pin_stat_i, lat_stat_i, irq_src_o;
  logic        core_stb_i, core_ack_i, core_busy_i, core_dir_i;
  logic        test_o, ack_hs_o, busy_hs_o, diag_o, ack_dir_o, busy_dir_o;
  logic        stb_dir_o, mclr_src_o, mclr_en_o, srst_o;
  logic        stb_o, ack_o, busy_o, dir_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pp_port_cfg dut (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v); chk("R1 timing reset", v, 16'h0000);
    chk("R1 width reset", {9'd0, width_ld_o}, 16'd3);
    rd(2'd1, v); chk("R1 op reset", v, 16'h200A);
  endtask

  task automatic t_timing;
    logic [15:0] v;
    wr(2'd0, 16'h7FFF);
    rd(2'd0, v); chk("R2 timing rw bit7 zero", v, 16'h7F7F);
    chk("R2 setup out", {9'd0, setup_o}, 16'h007F);
    wr(2'd0, 16'h1234);
    rd(2'd0, v); chk("R2 timing pattern", v, 16'h1234);
  endtask

  task automatic t_clamp;
    for (int w = 0; w < 6; w++) begin
      wr(2'd0, 16'(w << 8));
      chk("R3 width clamp", {9'd0, width_ld_o}, 16'(w < 3 ? 3 : w));
    end
  endtask

  task automatic t_op;
    logic [15:0] v;
    idle_i = 1'b0;
    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); chk("R4 op all ones", v, 16'hFF82);
    chk("R5 ctl outputs", {8'd0, mclr_en_o, mclr_src_o, stb_dir_o, busy_dir_o,
        ack_dir_o, diag_o, busy_hs_o, ack_hs_o}, 16'h00FF);
    wr(2'd1, 16'h0000);
    rd(2'd1, v); chk("R4 op all zeros", v, 16'h0002);
    idle_i = 1'b1; #1;
    rd(2'd1, v); chk("R4 idle live", v, 16'h000A);
    wr(2'd1, 16'h0900);
    chk("R5 ack_hs ack_dir", {14'd0, ack_hs_o, ack_dir_o}, 16'h0003);
    chk("R5 others clear", {12'd0, busy_hs_o, stb_dir_o, diag_o, mclr_en_o}, 16'h0000);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_srst;
    logic [15:0] v;
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h0080);
    chk("R6 srst set", {15'd0, srst_o}, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R6 srst held", {15'd0, srst_o}, 16'h0001);
    rd(2'd0, v); chk("R6 timing kept", v, 16'h1234);
    rd(2'd1, v); chk("R6 op read", v, 16'h008A);
    wr(2'd1, 16'h0000);
    chk("R6 srst cleared", {15'd0, srst_o}, 16'h0000);
  endtask

  task automatic t_test;
    logic [15:0] v;
    cnt_setup_i = 7'h15; cnt_width_i = 7'h2A;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R7 counter readback", v, 16'hAA15);
    chk("R7 test out", {15'd0, test_o}, 16'h0001);
    wr(2'd0, 16'h0505);
    rd(2'd0, v); chk("R7 test off", v, 16'h0505);
  endtask

  task automatic t_diag;
    logic [15:0] v;
    out_data_i = 8'hA5; pin_data_i = 8'h3A;
    pin_stat_i = 3'b001; lat_stat_i = 3'b110;
    core_stb_i = 1'b1; core_ack_i = 1'b1; core_busy_i = 1'b0; core_dir_i = 1'b1;
    #1;
    rd(2'd2, v); chk("R8 normal input", v, 16'h013A);
    chk("R9 normal irq", {13'd0, irq_src_o}, 16'h0001);
    chk("R10 normal pins", {12'd0, stb_o, ack_o, busy_o, dir_o}, 16'h000D);
    wr(2'd1, 16'h0400);
    rd(2'd2, v); chk("R8 R9 diag input", v, 16'h063D);
    chk("R9 diag irq", {13'd0, irq_src_o}, 16'h0006);
    core_dir_i = 1'b0; #1;
    chk("R10 diag pins", {12'd0, stb_o, ack_o, busy_o, dir_o}, 16'h0003);
    repeat (2) @(negedge clk);
    chk("R10 dir frozen", {15'd0, dir_o}, 16'h0001);
    wr(2'd1, 16'h0000);
    chk("R10 dir released", {15'd0, dir_o}, 16'h0000);
    rd(2'd2, v); chk("R8 exit diag", v, 16'h013A);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = '0; idle_i = 1'b1;
    cnt_setup_i = '0; cnt_width_i = '0; out_data_i = '0; pin_data_i = '0;
    pin_stat_i = '0; lat_stat_i = '0; core_stb_i = 1'b0; core_ack_i = 1'b0;
    core_busy_i = 1'b0; core_dir_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_timing();
    t_clamp();
    t_op();
    t_srst();
    t_test();
    t_diag();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule